// File: doc/BRIEF.md
# Serial Flash Status and Write-Guard Logic

This block is the status register and write-protection core of a serial NOR flash device, seen from the device side. It holds one 8-bit status word and shifts it out on the serial data output when a read-status command arrives. It decides whether each write-status, page-program, sector-erase, block-erase and chip-erase command is accepted or dropped. An accepted operation is launched towards an array engine over a start/done handshake.

A command decoder outside the block supplies one-cycle command strobes, the target address and the chip-select level. It also passes on the serial data bits of a write-status command. The protection fields are modelled as registers. A soft reset leaves them unchanged and only the power-on reset clears them. The volatile busy flag and write latch are cleared by either reset. Protection comes from three sources. The write latch must be set. A protection level selects a region at the top of the array. A hardware lock combines the lock bit with the guard pin, unless quad mode has taken that pin over as a data line.

Top module: `fsr_ctrl`

## Requirements
- R1: The status word is, from bit 7 down to bit 0: stat_lock, quad_mode, prot_lvl[3:0], wr_latch, busy. It is shifted out on sdo most significant bit first.
- R2: A read-status strobe while sel_n is low starts the shift-out. sdo carries bit 7 in the cycle after the strobe and one further bit each cycle. The word is recaptured every 8 bits, so the read repeats with live values until sel_n goes high. sdo_oe is high exactly while that read is running and sel_n is low; otherwise sdo is 0.
- R3: With busy at 0, a write-enable strobe sets wr_latch and a write-disable strobe clears it.
- R4: While busy is 1, every command except read-status is ignored.
- R5: Program, erase and write-status commands are ignored while wr_latch is 0.
- R6: Protection level L covers the top min(2^(L-1), N) of the N 64 KB blocks, and level 0 covers none. A program, sector erase or block erase whose address falls in a covered block is ignored and leaves wr_latch unchanged.
- R7: A chip erase is accepted only when prot_lvl is 0.
- R8: An accepted command raises eng_start for one cycle, starting in the cycle after acceptance. In that same cycle busy becomes 1, and eng_op and eng_addr are valid. The eng_op codes are 0 program, 1 sector erase, 2 block erase, 3 chip erase and 4 status write; eng_addr is 0 for a status write.
- R9: eng_done while busy is 1 clears busy and wr_latch on the next cycle. Only at that moment does an accepted status write copy its bits 7..2 into stat_lock, quad_mode and prot_lvl. The protection fields change at no other time except power-on reset.
- R10: Write-status data bits arrive MSB first, and the command is launched when sel_n rises after exactly 8 bits. Any other bit count drops the command and leaves wr_latch at 1.
- R11: With stat_lock at 1, hw_guard_n at 0 and quad_mode at 0, a write-status command is rejected and wr_latch is kept.
- R12: With quad_mode at 1, hw_guard_n has no effect on the acceptance of a write-status command.
- R13: Power-on reset clears the whole status word to 0. Soft reset clears busy and wr_latch, keeps the protection fields, and causes a later stale eng_done to be ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous soft reset, active high |
| por | input | 1 | Synchronous power-on reset, active high |
| sel_n | input | 1 | Chip-select level, active low |
| hw_guard_n | input | 1 | Write-guard pin, active low |
| cmd_wr_en | input | 1 | Write-enable strobe |
| cmd_wr_dis | input | 1 | Write-disable strobe |
| cmd_rd_stat | input | 1 | Read-status strobe |
| cmd_wr_stat | input | 1 | Write-status strobe |
| cmd_prog | input | 1 | Page-program strobe |
| cmd_sec_erase | input | 1 | Sector-erase strobe |
| cmd_blk_erase | input | 1 | Block-erase strobe |
| cmd_chip_erase | input | 1 | Chip-erase strobe |
| cmd_addr | input | ADDR_W | Target byte address |
| wr_bit_vld | input | 1 | Write-status data bit valid |
| wr_bit | input | 1 | Write-status data bit |
| eng_done | input | 1 | Array engine completion pulse |
| sdo | output | 1 | Serial status output |
| sdo_oe | output | 1 | Serial output enable |
| eng_start | output | 1 | Operation launch pulse |
| eng_op | output | 3 | Operation code |
| eng_addr | output | ADDR_W | Operation address |

## Verification
The bench builds the block with its default parameters: a 21-bit address and 64 KB blocks, which gives 32 blocks. With these values, levels 6 to 15 all cover the whole array, so the saturation of the protection map is reached with level 15. Addresses are placed just inside and just outside the covered region. An engine latency of 40 cycles keeps operations long enough for reads and refused commands to land while busy is high. A continuous read runs across a completion, so the live recapture at each byte boundary is exercised.

// File: rtl/fsr_pkg.sv
package fsr_pkg;

    localparam int STAT_W = 8;

    typedef enum logic [2:0] {
        OP_PROG = 3'd0,
        OP_SEC  = 3'd1,
        OP_BLK  = 3'd2,
        OP_CHIP = 3'd3,
        OP_STAT = 3'd4
    } op_e;

    typedef struct packed {
        logic       stat_lock;
        logic       quad_mode;
        logic [3:0] prot_lvl;
    } nv_t;

    typedef struct packed {
        nv_t  nv;
        logic wr_latch;
        logic busy;
    } stat_t;

    // Covered block count grows from the top of the array and saturates at nblk.
    function automatic logic region_hit(input logic [3:0] lvl,
                                        input int unsigned blk,
                                        input int unsigned nblk);
        int unsigned covered;
        if (lvl == 4'd0) covered = 0;
        else             covered = 32'd1 << (lvl - 4'd1);
        if (covered > nblk) covered = nblk;
        return (blk + covered) >= nblk;
    endfunction

endpackage

// File: rtl/fsr_protect.sv
module fsr_protect
    import fsr_pkg::*;
#(
    parameter int ADDR_W = 21,
    parameter int BLK_W  = 16
) (
    input  logic [ADDR_W-BLK_W-1:0] blk_idx,
    input  logic [3:0]              lvl,
    output logic                    hit
);
    localparam int unsigned NBLK = 32'd1 << (ADDR_W - BLK_W);

    always_comb begin
        hit = region_hit(lvl, 32'(blk_idx), NBLK);
    end
endmodule

// File: rtl/fsr_wrsr_rx.sv
module fsr_wrsr_rx
    import fsr_pkg::*;
(
    input  logic clk,
    input  logic clr,
    input  logic open_req,
    input  logic sel_n,
    input  logic sel_rise,
    input  logic bit_vld,
    input  logic bit_in,
    output logic active,
    output logic commit,
    output nv_t  field_o
);
    localparam int CNT_W = $clog2(STAT_W + 2);
    localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(STAT_W);
    localparam logic [CNT_W-1:0] CNT_OVER = CNT_W'(STAT_W + 1);

    logic [CNT_W-1:0]  cnt_q;
    logic [STAT_W-1:0] sh_q;

    always_ff @(posedge clk) begin
        if (clr) begin
            active <= 1'b0;
            cnt_q  <= '0;
            sh_q   <= '0;
        end else if (sel_rise) begin
            active <= 1'b0;
        end else if (open_req) begin
            active <= 1'b1;
            cnt_q  <= '0;
        end else if (active && bit_vld && !sel_n) begin
            sh_q <= {sh_q[STAT_W-2:0], bit_in};
            if (cnt_q != CNT_OVER) cnt_q <= cnt_q + 1'b1;
        end
    end

    assign commit  = active && sel_rise && (cnt_q == CNT_FULL);
    assign field_o = sh_q[STAT_W-1:2];
endmodule

// File: rtl/fsr_readout.sv
module fsr_readout
    import fsr_pkg::*;
(
    input  logic              clk,
    input  logic              clr,
    input  logic              sel_n,
    input  logic              start,
    input  logic [STAT_W-1:0] word,
    output logic              sdo,
    output logic              sdo_oe
);
    localparam int POS_W = $clog2(STAT_W);

    logic              run_q;
    logic [POS_W-1:0]  left_q;
    logic [STAT_W-1:0] sh_q;

    always_ff @(posedge clk) begin
        if (clr) begin
            run_q  <= 1'b0;
            left_q <= '0;
            sh_q   <= '0;
        end else if (sel_n) begin
            run_q <= 1'b0;
        end else if (start) begin
            run_q  <= 1'b1;
            sh_q   <= word;
            left_q <= POS_W'(STAT_W - 1);
        end else if (run_q) begin
            if (left_q == '0) begin
                sh_q   <= word;
                left_q <= POS_W'(STAT_W - 1);
            end else begin
                sh_q   <= {sh_q[STAT_W-2:0], 1'b0};
                left_q <= left_q - 1'b1;
            end
        end
    end

    assign sdo_oe = run_q && !sel_n;
    assign sdo    = sdo_oe ? sh_q[STAT_W-1] : 1'b0;
endmodule

// File: rtl/fsr_ctrl.sv
module fsr_ctrl
    import fsr_pkg::*;
#(
    parameter int ADDR_W = 21,
    parameter int BLK_W  = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              por,
    input  logic              sel_n,
    input  logic              hw_guard_n,
    input  logic              cmd_wr_en,
    input  logic              cmd_wr_dis,
    input  logic              cmd_rd_stat,
    input  logic              cmd_wr_stat,
    input  logic              cmd_prog,
    input  logic              cmd_sec_erase,
    input  logic              cmd_blk_erase,
    input  logic              cmd_chip_erase,
    input  logic [ADDR_W-1:0] cmd_addr,
    input  logic              wr_bit_vld,
    input  logic              wr_bit,
    input  logic              eng_done,
    output logic              sdo,
    output logic              sdo_oe,
    output logic              eng_start,
    output logic [2:0]        eng_op,
    output logic [ADDR_W-1:0] eng_addr
);
    logic  busy_q, latch_q, sel_q;
    nv_t   nv_q, pend_q, rx_field;
    op_e   op_q, op_sel;
    stat_t stat_w;
    logic  clr, sel_rise, idle, hw_locked, addr_prot;
    logic  ok_prog, ok_sec, ok_blk, ok_chip, ok_wren, ok_wrdi;
    logic  rx_open, rx_active, rx_commit, launch, completion;

    assign clr       = rst || por;
    assign sel_rise  = sel_n && !sel_q;
    assign idle      = !busy_q;
    assign hw_locked = nv_q.stat_lock && !hw_guard_n && !nv_q.quad_mode;

    fsr_protect #(.ADDR_W(ADDR_W), .BLK_W(BLK_W)) u_prot (
        .blk_idx (cmd_addr[ADDR_W-1:BLK_W]),
        .lvl     (nv_q.prot_lvl),
        .hit     (addr_prot)
    );

    assign ok_wren = cmd_wr_en  && idle;
    assign ok_wrdi = cmd_wr_dis && idle;
    assign ok_prog = cmd_prog       && idle && latch_q && !addr_prot;
    assign ok_sec  = cmd_sec_erase  && idle && latch_q && !addr_prot;
    assign ok_blk  = cmd_blk_erase  && idle && latch_q && !addr_prot;
    assign ok_chip = cmd_chip_erase && idle && latch_q && (nv_q.prot_lvl == 4'd0);
    assign rx_open = cmd_wr_stat    && idle && latch_q && !hw_locked && !sel_n;

    fsr_wrsr_rx u_rx (
        .clk      (clk),
        .clr      (clr),
        .open_req (rx_open),
        .sel_n    (sel_n),
        .sel_rise (sel_rise),
        .bit_vld  (wr_bit_vld),
        .bit_in   (wr_bit),
        .active   (rx_active),
        .commit   (rx_commit),
        .field_o  (rx_field)
    );

    assign launch     = rx_commit || ok_prog || ok_sec || ok_blk || ok_chip;
    assign completion = busy_q && eng_done;

    always_comb begin
        if      (rx_commit) op_sel = OP_STAT;
        else if (ok_chip)   op_sel = OP_CHIP;
        else if (ok_blk)    op_sel = OP_BLK;
        else if (ok_sec)    op_sel = OP_SEC;
        else                op_sel = OP_PROG;
    end

    always_ff @(posedge clk) begin
        if (clr) begin
            busy_q    <= 1'b0;
            latch_q   <= 1'b0;
            sel_q     <= 1'b1;
            eng_start <= 1'b0;
            op_q      <= OP_PROG;
            eng_addr  <= '0;
            pend_q    <= '0;
            if (por) nv_q <= '0;
        end else begin
            sel_q     <= sel_n;
            eng_start <= launch;
            if (launch) begin
                busy_q   <= 1'b1;
                op_q     <= op_sel;
                eng_addr <= rx_commit ? '0 : cmd_addr;
                if (rx_commit) pend_q <= rx_field;
            end else if (completion) begin
                busy_q  <= 1'b0;
                latch_q <= 1'b0;
                if (op_q == OP_STAT) nv_q <= pend_q;
            end else if (ok_wren) begin
                latch_q <= 1'b1;
            end else if (ok_wrdi) begin
                latch_q <= 1'b0;
            end
        end
    end

    assign eng_op = op_q;

    always_comb begin
        stat_w.nv       = nv_q;
        stat_w.wr_latch = latch_q;
        stat_w.busy     = busy_q;
    end

    fsr_readout u_rd (
        .clk    (clk),
        .clr    (clr),
        .sel_n  (sel_n),
        .start  (cmd_rd_stat),
        .word   (stat_w),
        .sdo    (sdo),
        .sdo_oe (sdo_oe)
    );
endmodule

// File: rtl/fsr_ctrl_chk.sv
module fsr_ctrl_chk (
    input logic       clk,
    input logic       rst,
    input logic       por,
    input logic       sel_n,
    input logic       hw_guard_n,
    input logic       cmd_wr_stat,
    input logic       cmd_prog,
    input logic       cmd_sec_erase,
    input logic       cmd_blk_erase,
    input logic       cmd_chip_erase,
    input logic       eng_start,
    input logic       eng_done,
    input logic       busy,
    input logic       latch,
    input logic [5:0] nv,
    input logic       rx_active
);
    p_start_busy_r8: assert property (@(posedge clk) disable iff (rst || por)
        eng_start |-> busy);

    p_done_clears_r9: assert property (@(posedge clk) disable iff (rst || por)
        (busy && eng_done) |=> (!busy && !latch));

    p_nv_hold_r9: assert property (@(posedge clk) disable iff (rst || por)
        !(busy && eng_done) |=> $stable(nv));

    p_busy_ignore_r4: assert property (@(posedge clk) disable iff (rst || por)
        (busy && !eng_done) |=> (busy && !eng_start));

    p_latch_gate_r5: assert property (@(posedge clk) disable iff (rst || por)
        ((cmd_prog || cmd_sec_erase || cmd_blk_erase || cmd_chip_erase) && !latch)
        |=> !eng_start);

    p_chip_guard_r7: assert property (@(posedge clk) disable iff (rst || por)
        (cmd_chip_erase && nv[3:0] != 4'd0) |=> !eng_start);

    p_hw_lock_r11: assert property (@(posedge clk) disable iff (rst || por)
        (cmd_wr_stat && nv[5] && !nv[4] && !hw_guard_n) |=> !rx_active);

    p_quad_free_r12: assert property (@(posedge clk) disable iff (rst || por)
        (cmd_wr_stat && !sel_n && !busy && latch && nv[4]) |=> rx_active);
endmodule

bind fsr_ctrl fsr_ctrl_chk u_chk (
    .clk            (clk),
    .rst            (rst),
    .por            (por),
    .sel_n          (sel_n),
    .hw_guard_n     (hw_guard_n),
    .cmd_wr_stat    (cmd_wr_stat),
    .cmd_prog       (cmd_prog),
    .cmd_sec_erase  (cmd_sec_erase),
    .cmd_blk_erase  (cmd_blk_erase),
    .cmd_chip_erase (cmd_chip_erase),
    .eng_start      (eng_start),
    .eng_done       (eng_done),
    .busy           (busy_q),
    .latch          (latch_q),
    .nv             (nv_q),
    .rx_active      (rx_active)
);

// File: tb/fsr_ctrl_tb.sv
module fsr_ctrl_tb;
    localparam int ADDR_W  = 21;
    localparam int BLK_W   = 16;
    localparam int CLK_PER = 10;
    localparam int ENG_LAT = 40;
    localparam int NBLK    = 1 << (ADDR_W - BLK_W);

    logic clk = 0;
    logic rst = 1, por = 1, sel_n = 1, hw_guard_n = 1;
    logic cmd_wr_en = 0, cmd_wr_dis = 0, cmd_rd_stat = 0, cmd_wr_stat = 0;
    logic cmd_prog = 0, cmd_sec_erase = 0, cmd_blk_erase = 0, cmd_chip_erase = 0;
    logic [ADDR_W-1:0] cmd_addr = '0;
    logic wr_bit_vld = 0, wr_bit = 0, eng_done = 0;
    logic sdo, sdo_oe, eng_start;
    logic [2:0] eng_op;
    logic [ADDR_W-1:0] eng_addr;

    int checks = 0, failures = 0;
    bit cmp_en = 0, finished = 0;

    always #(CLK_PER/2) clk = ~clk;

    fsr_ctrl #(.ADDR_W(ADDR_W), .BLK_W(BLK_W)) u_dut (.*);

    // behavioural reference state
    int m_busy = 0, m_latch = 0, m_lock = 0, m_quad = 0, m_lvl = 0;
    int m_op = 0, m_pend = 0, m_addr = 0, m_start = 0, m_selp = 1;
    int m_rx_on = 0, m_rx_n = 0, m_rx_val = 0;
    int m_rd_on = 0, m_rd_word = 0, m_rd_pos = 0;
    int eng_cnt = 0;

    function automatic int covered(input int lvl, input int a);
        int blocks;
        blocks = (lvl == 0) ? 0 : (1 << (lvl - 1));
        if (blocks > NBLK) blocks = NBLK;
        return ((a >> BLK_W) >= (NBLK - blocks)) ? 1 : 0;
    endfunction

    always @(posedge clk) begin
        if (rst || por) begin
            m_busy = 0; m_latch = 0; m_start = 0; m_selp = 1;
            m_rx_on = 0; m_rd_on = 0; m_op = 0; m_addr = 0;
            if (por) begin m_lock = 0; m_quad = 0; m_lvl = 0; end
        end else begin
            int stat, rise, free, hit, locked, commit, go, gop;
            stat   = m_lock*128 + m_quad*64 + m_lvl*4 + m_latch*2 + m_busy;
            rise   = (sel_n && m_selp == 0) ? 1 : 0;
            free   = (m_busy == 0) ? 1 : 0;
            hit    = covered(m_lvl, int'(cmd_addr));
            locked = (m_lock == 1 && !hw_guard_n && m_quad == 0) ? 1 : 0;
            commit = (m_rx_on == 1 && rise == 1 && m_rx_n == 8) ? 1 : 0;
            go = 0; gop = 0;
            if (commit == 1) begin go = 1; gop = 4; end
            else if (free == 1 && m_latch == 1) begin
                if (cmd_chip_erase && m_lvl == 0) begin go = 1; gop = 3; end
                else if (cmd_blk_erase && hit == 0) begin go = 1; gop = 2; end
                else if (cmd_sec_erase && hit == 0) begin go = 1; gop = 1; end
                else if (cmd_prog && hit == 0) begin go = 1; gop = 0; end
            end
            // read-out
            if (sel_n) m_rd_on = 0;
            else if (cmd_rd_stat) begin m_rd_on = 1; m_rd_word = stat; m_rd_pos = 7; end
            else if (m_rd_on == 1) begin
                if (m_rd_pos == 0) begin m_rd_word = stat; m_rd_pos = 7; end
                else m_rd_pos = m_rd_pos - 1;
            end
            // write-status receiver
            if (rise == 1) m_rx_on = 0;
            else if (cmd_wr_stat && free == 1 && m_latch == 1 && locked == 0 && !sel_n) begin
                m_rx_on = 1; m_rx_n = 0;
            end else if (m_rx_on == 1 && wr_bit_vld && !sel_n) begin
                m_rx_val = (m_rx_val * 2 + int'(wr_bit)) % 256;
                if (m_rx_n < 9) m_rx_n = m_rx_n + 1;
            end
            m_start = go;
            if (go == 1) begin
                m_busy = 1; m_op = gop;
                m_addr = (gop == 4) ? 0 : int'(cmd_addr);
                if (commit == 1) m_pend = m_rx_val;
            end else if (m_busy == 1 && eng_done) begin
                m_busy = 0; m_latch = 0;
                if (m_op == 4) begin
                    m_lock = (m_pend >> 7) & 1;
                    m_quad = (m_pend >> 6) & 1;
                    m_lvl  = (m_pend >> 2) & 15;
                end
            end else if (free == 1 && cmd_wr_en) m_latch = 1;
            else if (free == 1 && cmd_wr_dis) m_latch = 0;
            m_selp = sel_n ? 1 : 0;
        end
    end

    // array engine stand-in, not cleared by soft reset
    always @(negedge clk) begin
        eng_done = 0;
        if (eng_start) eng_cnt = ENG_LAT;
        else if (eng_cnt > 0) begin
            eng_cnt = eng_cnt - 1;
            if (eng_cnt == 0) eng_done = 1;
        end
    end

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=0x%0h expected=0x%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // every-cycle comparison against the reference
    always @(negedge clk) begin
        #1;
        if (cmp_en) begin
            int oe;
            oe = (m_rd_on == 1 && !sel_n) ? 1 : 0;
            chk("R2 sdo_oe", int'(sdo_oe), oe);
            chk("R2 sdo", int'(sdo), (oe == 1) ? ((m_rd_word >> m_rd_pos) & 1) : 0);
            chk("R8 eng_start", int'(eng_start), m_start);
            if (m_start == 1) begin
                chk("R8 eng_op", int'(eng_op), m_op);
                chk("R8 eng_addr", int'(eng_addr), m_addr);
            end
        end
    end

    task automatic idle_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic issue(input int kind, input int a);
        @(negedge clk);
        sel_n = 0;
        cmd_addr = ADDR_W'(a);
        @(negedge clk);
        case (kind)
            0: cmd_wr_en = 1;
            1: cmd_wr_dis = 1;
            2: cmd_prog = 1;
            3: cmd_sec_erase = 1;
            4: cmd_blk_erase = 1;
            default: cmd_chip_erase = 1;
        endcase
        @(negedge clk);
        {cmd_wr_en, cmd_wr_dis, cmd_prog, cmd_sec_erase, cmd_blk_erase, cmd_chip_erase} = '0;
        sel_n = 1;
        @(negedge clk);
    endtask

    task automatic wstat(input logic [7:0] v, input int nbits);
        @(negedge clk);
        sel_n = 0;
        cmd_wr_stat = 1;
        @(negedge clk);
        cmd_wr_stat = 0;
        for (int i = 0; i < nbits; i++) begin
            wr_bit_vld = 1;
            wr_bit = (i < 8) ? v[7-i] : 1'b0;
            @(negedge clk);
        end
        wr_bit_vld = 0;
        sel_n = 1;
        idle_cyc(2);
    endtask

    task automatic rdstat(input logic [7:0] exp, input int nbytes, input string tag);
        @(negedge clk);
        sel_n = 0;
        cmd_rd_stat = 1;
        for (int b = 0; b < nbytes; b++) begin
            for (int i = 7; i >= 0; i--) begin
                @(negedge clk);
                cmd_rd_stat = 0;
                chk(tag, int'(sdo), int'(exp[i]));
            end
        end
        sel_n = 1;
        idle_cyc(1);
    endtask

    task automatic wait_free();
        while (m_busy != 0) @(negedge clk);
        idle_cyc(2);
    endtask

    initial begin
        idle_cyc(3);
        rst = 0; por = 0;
        cmp_en = 1;
        rdstat(8'h00, 1, "R13 power-on status");
        chk("R13 eng_start after reset", int'(eng_start), 0);

        issue(2, 0);                          // program with latch clear
        rdstat(8'h00, 1, "R5 program dropped");
        issue(0, 0);
        rdstat(8'h02, 1, "R3 write enable");
        issue(1, 0);
        rdstat(8'h00, 1, "R3 write disable");

        issue(0, 0);
        issue(2, 'h1000);                     // accepted program
        rdstat(8'h03, 1, "R8 busy during program");
        issue(1, 0);                          // disable while busy
        rdstat(8'h03, 1, "R4 disable ignored while busy");
        wait_free();
        rdstat(8'h00, 1, "R9 completion clears latch");

        issue(0, 0);
        wstat(8'h0C, 8);                      // level 3: top 4 blocks
        wait_free();
        rdstat(8'h0C, 1, "R10 status write applied");

        issue(0, 0);
        issue(3, 'h1F0000);
        rdstat(8'h0E, 1, "R6 erase in covered block dropped");
        issue(3, 'h1BFFFF);
        rdstat(8'h0F, 1, "R6 erase below region accepted");
        wait_free();

        issue(0, 0);
        issue(5, 0);
        rdstat(8'h0E, 1, "R7 chip erase refused");
        wstat(8'h00, 7);
        rdstat(8'h0E, 1, "R10 seven bits abort");
        wstat(8'h00, 9);
        rdstat(8'h0E, 1, "R10 nine bits abort");

        wstat(8'hC4, 8);
        wait_free();
        rdstat(8'hC4, 1, "R1 field layout");

        hw_guard_n = 0;
        issue(0, 0);
        wstat(8'h88, 8);                      // quad mode frees the guard pin
        wait_free();
        rdstat(8'h88, 1, "R12 guard pin ignored in quad mode");

        issue(0, 0);
        wstat(8'h00, 8);                      // locked now
        rdstat(8'h8A, 1, "R11 hardware lock rejects write");
        hw_guard_n = 1;
        wstat(8'h3C, 8);
        wait_free();
        rdstat(8'h3C, 1, "R10 level 15 written");

        issue(0, 0);
        issue(2, 0);
        issue(4, 'h0F0000);
        rdstat(8'h3E, 1, "R6 saturated level covers all");

        wstat(8'h00, 8);
        wait_free();
        issue(0, 0);
        issue(5, 0);
        rdstat(8'h03, 2, "R7 chip erase accepted");
        @(negedge clk);
        sel_n = 0;
        cmd_rd_stat = 1;
        @(negedge clk);
        cmd_rd_stat = 0;
        idle_cyc(64);                         // continuous read across completion
        sel_n = 1;
        idle_cyc(2);
        rdstat(8'h00, 1, "R2 after continuous read");

        issue(0, 0);
        wstat(8'h04, 8);
        wait_free();
        issue(0, 0);
        issue(2, 0);
        @(negedge clk);
        rst = 1;
        @(negedge clk);
        rst = 0;
        rdstat(8'h04, 1, "R13 soft reset keeps fields");
        idle_cyc(ENG_LAT + 5);
        rdstat(8'h04, 1, "R13 stale completion ignored");
        @(negedge clk);
        por = 1;
        @(negedge clk);
        por = 0;
        rdstat(8'h00, 1, "R13 power-on clears fields");

        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule